// File: doc/BRIEF.md
# Two-Stage Expiry Watchdog Timer

This block is a watchdog built around a down-counting timer that software controls through a small 32-bit register bus. Software writes an interval into the reload register and then arms the timer. If the timer runs out, the block does not reset the system straight away. It raises an early-warning interrupt and reloads itself with a shorter hard interval taken from the build parameters. A system reset follows only if that second interval also runs out without a keepalive.

A keepalive is a read of the interrupt-acknowledge word. It drops the pending interrupt and restarts the long interval. The owning software can also give up the watchdog through a release pulse. A release on an armed timer grants one more full interval and locks the configuration, so the reset cannot be avoided afterwards. If the counter runs out while the watchdog mode is not set, the expiry is treated as spurious: the counter stops at zero and no interrupt or reset follows.

Top module: `wdt_two_stage`

## Requirements
- R1: After reset, wd_irq and wd_sys_rst are 0, the control word reads 0, the status word reads 1, and the reload word reads the soft interval ((PERIOD_S-MARGIN_S)*TICK_HZ/FREQ_ADJ, which is 14 with the default parameters).
- R2: Word addresses are fixed: 0 reload, 1 live count, 2 control, 3 interrupt acknowledge, 4 status. Read data appears on bus_rdata in the cycle after the read strobe. A nonzero write to the reload word reads back unchanged on the next read, and a write of 0 is ignored.
- R3: In the control word, bit 0 is run and bit 1 is watchdog mode. Writing 3 arms the watchdog and starts counting. Writing 2 holds the counter, and the live count stays frozen at its value. Writing 0 stops and disarms the watchdog, so no interrupt or reset follows.
- R4: While the watchdog is armed and running, the counter steps down once per tick. After N ticks from a reload value N, wd_irq rises and the counter reloads with the hard interval (MARGIN_S*TICK_HZ/FREQ_ADJ, which is 6 by default).
- R5: If the hard interval runs out with no keepalive, wd_sys_rst rises and stays high until rst, and the counter stops.
- R6: A read of word 3 while armed clears wd_irq, reloads the counter from the reload word and returns to the soft stage, so the next expiry again raises only the interrupt.
- R7: The status word reads 0 while an expiry interrupt is pending and 1 otherwise.
- R8: When the counter runs out while the mode bit is clear (control written 1), the counter stops at 0, the run bit clears, and neither wd_irq nor wd_sys_rst rises.
- R9: An owner_release pulse while armed reloads the soft interval and locks the block. While locked, writes to control and reload are ignored and a read of word 3 only clears wd_irq, so the reset follows after a soft and a hard interval. A release while not armed has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| owner_release | input | 1 | Owner gives up the watchdog |
| wd_irq | output | 1 | Early-warning interrupt, level |
| wd_sys_rst | output | 1 | System reset request, held high |

## Verification
The assertions check on every cycle that a raised reset stays high and that it rises only from the hard stage. They also check that the interrupt rises only on the move into the hard stage, that the lock never clears, that a stopped counter holds its value, and that the status word has the right polarity. Only the bench scenarios can show the exact tick count of each interval, the effect of a keepalive, and the spurious stop. They are also needed to show that a locked block ignores writes and still resets, and that a release on an unarmed block changes nothing.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {ST_SOFT = 1'b0, ST_HARD = 1'b1} stage_t;

  localparam logic [2:0] A_RELOAD = 3'd0;
  localparam logic [2:0] A_COUNT  = 3'd1;
  localparam logic [2:0] A_CTRL   = 3'd2;
  localparam logic [2:0] A_ACK    = 3'd3;
  localparam logic [2:0] A_STAT   = 3'd4;

  localparam logic [1:0] CTRL_OFF  = 2'b00;
  localparam logic [1:0] CTRL_ARM  = 2'b11;
endpackage

// File: rtl/wdt_tick.sv
module wdt_tick #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else begin
      div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
      tick  <= (div_q == LAST);
    end
  end
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter logic [CNT_W-1:0] SOFT_INIT = 14,
  parameter logic [CNT_W-1:0] HARD_TICKS = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  input  logic             ctrl_we,
  input  logic [1:0]       ctrl_val,
  input  logic             ack,
  input  logic             release_req,
  output logic [CNT_W-1:0] load_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run_q,
  output logic             mode_q,
  output logic             irq_q,
  output logic             srst_q
);
  logic   armed_q, locked_q;
  stage_t stage_q;

  logic open_cfg, rel_ok, ack_reload, reload, ctrl_ok, load_ok;
  logic count_step, expire, watch;

  always_comb begin
    open_cfg   = !locked_q && !srst_q;
    rel_ok     = release_req && armed_q && open_cfg;
    ack_reload = ack && armed_q && open_cfg;
    reload     = rel_ok || ack_reload;
    ctrl_ok    = ctrl_we && open_cfg;
    load_ok    = load_we && open_cfg && (load_val != '0);
    count_step = run_q && tick && !srst_q && !reload && !ctrl_ok && !load_ok;
    expire     = count_step && (cnt_q <= CNT_W'(1));
    watch      = armed_q && mode_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q   <= SOFT_INIT;
      cnt_q    <= SOFT_INIT;
      run_q    <= 1'b0;
      mode_q   <= 1'b0;
      irq_q    <= 1'b0;
      srst_q   <= 1'b0;
      armed_q  <= 1'b0;
      locked_q <= 1'b0;
      stage_q  <= ST_SOFT;
    end else begin
      if (ack || rel_ok) irq_q <= 1'b0;
      if (reload) begin
        cnt_q   <= load_q;
        stage_q <= ST_SOFT;
        if (rel_ok) locked_q <= 1'b1;
      end else if (ctrl_ok) begin
        run_q  <= ctrl_val[0];
        mode_q <= ctrl_val[1];
        if (ctrl_val == CTRL_OFF) begin
          armed_q <= 1'b0;
          stage_q <= ST_SOFT;
          irq_q   <= 1'b0;
        end else if (ctrl_val == CTRL_ARM) begin
          armed_q <= 1'b1;
        end
      end else if (load_ok) begin
        load_q <= load_val;
        cnt_q  <= load_val;
      end else if (count_step) begin
        if (!expire) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (!watch) begin
          cnt_q <= '0;
          run_q <= 1'b0;
        end else if (stage_q == ST_SOFT) begin
          irq_q   <= 1'b1;
          cnt_q   <= HARD_TICKS;
          stage_q <= ST_HARD;
        end else begin
          srst_q <= 1'b1;
          run_q  <= 1'b0;
          cnt_q  <= '0;
        end
      end
    end
  end

  AST_RST_STICKY: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> srst_q); // R5
  AST_RST_FROM_HARD: assert property (@(posedge clk) disable iff (rst)
    $rose(srst_q) |-> $past(stage_q == ST_HARD)); // R5
  AST_IRQ_ENTERS_HARD: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> (stage_q == ST_HARD) && $past(stage_q == ST_SOFT)); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    locked_q |=> locked_q); // R9
  AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !reload && !load_ok) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int DW = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [2:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [CNT_W-1:0] load_q,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             run_q,
  input  logic             mode_q,
  input  logic             irq_q,
  output logic             load_we,
  output logic [CNT_W-1:0] load_val,
  output logic             ctrl_we,
  output logic [1:0]       ctrl_val,
  output logic             ack
);
  logic [DW-1:0] rd_d;

  always_comb begin
    load_we  = bus_wr && (bus_addr == A_RELOAD);
    ctrl_we  = bus_wr && (bus_addr == A_CTRL);
    ack      = bus_rd && (bus_addr == A_ACK);
    load_val = CNT_W'(bus_wdata);
    ctrl_val = bus_wdata[1:0];
    case (bus_addr)
      A_RELOAD: rd_d = DW'(load_q);
      A_COUNT:  rd_d = DW'(cnt_q);
      A_CTRL:   rd_d = DW'({mode_q, run_q});
      A_STAT:   rd_d = DW'(!irq_q);
      default:  rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_d;
  end

  AST_STATUS_POLARITY: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == A_STAT) |=> bus_rdata == DW'(!$past(irq_q))); // R7
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int DW       = 32,
  parameter int CNT_W    = 32,
  parameter int PERIOD_S = 10,
  parameter int MARGIN_S = 3,
  parameter int TICK_HZ  = 4,
  parameter int FREQ_ADJ = 2,
  parameter int TICK_DIV = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          owner_release,
  output logic          wd_irq,
  output logic          wd_sys_rst
);
  localparam int SOFT_T = (PERIOD_S - MARGIN_S) * TICK_HZ / FREQ_ADJ;
  localparam int HARD_T = MARGIN_S * TICK_HZ / FREQ_ADJ;
  localparam logic [CNT_W-1:0] SOFT_INIT  = CNT_W'(SOFT_T);
  localparam logic [CNT_W-1:0] HARD_TICKS = CNT_W'(HARD_T);

  logic             tick;
  logic             load_we, ctrl_we, ack;
  logic [CNT_W-1:0] load_val, load_q, cnt_q;
  logic [1:0]       ctrl_val;
  logic             run_q, mode_q;

  wdt_tick #(.DIV(TICK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  wdt_regs #(.DW(DW), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .load_q   (load_q),
    .cnt_q    (cnt_q),
    .run_q    (run_q),
    .mode_q   (mode_q),
    .irq_q    (wd_irq),
    .load_we  (load_we),
    .load_val (load_val),
    .ctrl_we  (ctrl_we),
    .ctrl_val (ctrl_val),
    .ack      (ack)
  );

  wdt_core #(
    .CNT_W     (CNT_W),
    .SOFT_INIT (SOFT_INIT),
    .HARD_TICKS(HARD_TICKS)
  ) u_core (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .load_we    (load_we),
    .load_val   (load_val),
    .ctrl_we    (ctrl_we),
    .ctrl_val   (ctrl_val),
    .ack        (ack),
    .release_req(owner_release),
    .load_q     (load_q),
    .cnt_q      (cnt_q),
    .run_q      (run_q),
    .mode_q     (mode_q),
    .irq_q      (wd_irq),
    .srst_q     (wd_sys_rst)
  );
endmodule

// File: tb/wdt_two_stage_tb.sv
module wdt_two_stage_tb;
  localparam int DW = 32;
  localparam int PERIOD_S = 10, MARGIN_S = 3, TICK_HZ = 4, FREQ_ADJ = 2;
  localparam int EXP_SOFT = (PERIOD_S - MARGIN_S) * TICK_HZ / FREQ_ADJ;
  localparam int EXP_HARD = MARGIN_S * TICK_HZ / FREQ_ADJ;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, owner_release = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic wd_irq, wd_sys_rst;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  wdt_two_stage #(.DW(DW), .PERIOD_S(PERIOD_S), .MARGIN_S(MARGIN_S),
                  .TICK_HZ(TICK_HZ), .FREQ_ADJ(FREQ_ADJ)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .owner_release(owner_release), .wd_irq(wd_irq), .wd_sys_rst(wd_sys_rst)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(2);
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [DW-1:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_release();
    owner_release = 1'b1;
    @(negedge clk);
    owner_release = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [DW-1:0] d;
    do_reset();
    check("R1 irq", DW'(wd_irq), 0);
    check("R1 sys_rst", DW'(wd_sys_rst), 0);
    bus_read(3'd2, d); check("R1 control", d, 0);
    bus_read(3'd4, d); check("R1 status", d, 1);
    bus_read(3'd0, d); check("R1 reload", d, EXP_SOFT);
  endtask

  task automatic t_readback();
    logic [DW-1:0] d;
    do_reset();
    bus_write(3'd0, 32'h1234_0005);
    bus_read(3'd0, d); check("R2 reload readback", d, 32'h1234_0005);
    check("R2 upper half", {16'h0, d[31:16]}, 32'h1234);
    bus_write(3'd0, 32'h0);
    bus_read(3'd0, d); check("R2 zero write ignored", d, 32'h1234_0005);
  endtask

  task automatic t_freeze();
    logic [DW-1:0] d;
    do_reset();
    bus_write(3'd0, 20);
    bus_write(3'd2, 3);
    wait_cyc(5);
    bus_write(3'd2, 2);
    bus_read(3'd1, d); check("R3 held count", d, 15);
    wait_cyc(10);
    bus_read(3'd1, d); check("R3 count frozen", d, 15);
    bus_read(3'd2, d); check("R3 control hold", d, 2);
    check("R3 no irq while held", DW'(wd_irq), 0);
  endtask

  task automatic t_two_stage();
    logic [DW-1:0] d;
    do_reset();
    bus_write(3'd0, 8);
    bus_write(3'd2, 3);
    wait_cyc(7);
    check("R4 irq before expiry", DW'(wd_irq), 0);
    wait_cyc(1);
    check("R4 irq at expiry", DW'(wd_irq), 1);
    bus_read(3'd4, d); check("R7 status pending", d, 0);
    check("R4 no reset at first expiry", DW'(wd_sys_rst), 0);
    wait_cyc(EXP_HARD - 2);
    check("R5 reset before hard end", DW'(wd_sys_rst), 0);
    wait_cyc(1);
    check("R5 reset at hard end", DW'(wd_sys_rst), 1);
    wait_cyc(10);
    check("R5 reset held", DW'(wd_sys_rst), 1);
    bus_read(3'd2, d); check("R5 counter stopped", d, 2);
  endtask

  task automatic t_keepalive();
    logic [DW-1:0] d;
    do_reset();
    bus_write(3'd0, 8);
    bus_write(3'd2, 3);
    wait_cyc(8);
    check("R6 irq raised", DW'(wd_irq), 1);
    bus_read(3'd3, d);
    check("R6 irq cleared", DW'(wd_irq), 0);
    bus_read(3'd4, d); check("R7 status idle", d, 1);
    wait_cyc(6);
    check("R6 soft interval restarted", DW'(wd_irq), 0);
    wait_cyc(1);
    check("R6 soft expiry again", DW'(wd_irq), 1);
    check("R6 no reset", DW'(wd_sys_rst), 0);
    bus_write(3'd2, 0);
  endtask

  task automatic t_spurious();
    logic [DW-1:0] d;
    do_reset();
    bus_write(3'd0, 5);
    bus_write(3'd2, 1);
    wait_cyc(10);
    check("R8 no irq", DW'(wd_irq), 0);
    check("R8 no reset", DW'(wd_sys_rst), 0);
    bus_read(3'd2, d); check("R8 run cleared", d, 0);
    bus_read(3'd1, d); check("R8 count zero", d, 0);
  endtask

  task automatic t_disarm();
    logic [DW-1:0] d;
    do_reset();
    bus_write(3'd0, 8);
    bus_write(3'd2, 3);
    wait_cyc(3);
    bus_write(3'd2, 0);
    wait_cyc(20);
    check("R3 off no irq", DW'(wd_irq), 0);
    check("R3 off no reset", DW'(wd_sys_rst), 0);
    bus_read(3'd1, d); check("R3 off count kept", d, 5);
  endtask

  task automatic t_release_locked();
    logic [DW-1:0] d;
    do_reset();
    bus_write(3'd0, 8);
    bus_write(3'd2, 3);
    wait_cyc(3);
    pulse_release();
    bus_write(3'd2, 0);
    bus_write(3'd0, 100);
    bus_read(3'd2, d); check("R9 control write ignored", d, 3);
    bus_read(3'd0, d); check("R9 reload write ignored", d, 8);
    wait_cyc(3);
    check("R9 irq before extra interval ends", DW'(wd_irq), 0);
    wait_cyc(1);
    check("R9 irq after extra interval", DW'(wd_irq), 1);
    bus_read(3'd3, d);
    check("R9 ack clears irq", DW'(wd_irq), 0);
    wait_cyc(EXP_HARD - 2);
    check("R9 no reset yet", DW'(wd_sys_rst), 0);
    wait_cyc(1);
    check("R9 ack gave no reload, reset", DW'(wd_sys_rst), 1);
  endtask

  task automatic t_release_unarmed();
    logic [DW-1:0] d;
    do_reset();
    pulse_release();
    bus_write(3'd0, 8);
    bus_write(3'd2, 3);
    bus_write(3'd2, 0);
    bus_read(3'd2, d); check("R9 unarmed release no lock", d, 0);
    bus_read(3'd0, d); check("R9 unarmed reload accepted", d, 8);
  endtask

  initial begin
    t_reset_state();
    t_readback();
    t_freeze();
    t_two_stage();
    t_keepalive();
    t_spurious();
    t_disarm();
    t_release_locked();
    t_release_unarmed();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule